// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the control half of a five-stage in-order integer pipeline. It carries no operand values, only register numbers and the control bits needed to detect data hazards. Each cycle it takes at most one fetched instruction, given as an operation class plus three register numbers. It moves that instruction's hazard fields through the four inter-stage registers: fetch/decode, decode/execute, execute/memory and memory/writeback. From their contents it derives the two operand forwarding selects and the load-use stall controls.

Six operations are handled: register add, immediate add, register or, immediate or, word load and word store. Register numbers 1 to 8 are meaningful. Every tracked inter-stage field is driven on an output port every cycle, so the whole control state can be watched as a trace. A field with no meaning in the current cycle reads as zero, for example a destination field of an immediate-form instruction or any field of an empty stage. When a load is followed at once by an instruction that reads the loaded register, the controller freezes fetch for one cycle and injects a bubble into execute. The environment then presents the same instruction again, because the program counter did not advance.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, every trace field and both forwarding selects read 0, pc_write_o and ifid_write_o read 1 and idex_flush_o reads 0.
- R2: op_i codes are 0 register add, 1 immediate add, 2 register or, 3 immediate or, 4 load, 5 store. With valid_i high, a legal code and no stall, the instruction appears in the fetch/decode fields on the next rising edge. rs and rt are passed as given, and rd is kept only for codes 0 and 2; otherwise it reads 0.
- R3: With valid_i low, or with op_i code 6 or 7, the fetch/decode fields read 0 after the next edge, whatever is on rs_i, rt_i and rd_i.
- R4: One edge after the fetch/decode stage, the decode/execute fields show rs, rt and rd. The register write bit is 1 for every class except store, the memory read bit is 1 only for load, and the destination select bit is 1 only for codes 0 and 2. The decode/execute rd reads 0 whenever the destination select bit is 0.
- R5: One edge after decode/execute, the execute/memory fields show the register write bit and the destination register. The destination is rd when the select bit is 1 and rt when it is 0, and it reads 0 when the write bit is 0. The memory/writeback fields repeat the execute/memory fields one edge later.
- R6: Forwarding select code 2'b10 takes the execute/memory result, 2'b01 takes the memory/writeback result and 2'b00 takes the register file. Select A matches the decode/execute rs. Select B matches the decode/execute rt only when that stage holds register add, register or or store; otherwise it reads 2'b00.
- R7: When both later stages match the same source register, the select reads 2'b10.
- R8: A stage whose write bit is 0, or whose destination is register 0, never causes forwarding.
- R9: A stall is flagged (pc_write_o=0, ifid_write_o=0, idex_flush_o=1) when decode/execute holds a load with nonzero rt, and that rt equals one of the following. The first is the fetch/decode rs of a valid instruction. The second is the fetch/decode rt when that instruction is register add, register or or store. An immediate add whose rt equals the load's rt does not stall.
- R10: After a stall cycle, the decode/execute fields and control bits read 0. The fetch/decode fields are unchanged, and the instruction presented during the stall cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A new instruction is presented |
| op_i | input | 3 | Operation class code |
| rs_i | input | 4 | First source register number |
| rt_i | input | 4 | Second source or immediate-form destination |
| rd_i | input | 4 | Register-form destination |
| ifid_rs_o | output | 4 | Fetch/decode rs |
| ifid_rt_o | output | 4 | Fetch/decode rt |
| ifid_rd_o | output | 4 | Fetch/decode rd |
| idex_rs_o | output | 4 | Decode/execute rs |
| idex_rt_o | output | 4 | Decode/execute rt |
| idex_rd_o | output | 4 | Decode/execute rd |
| idex_reg_write_o | output | 1 | Decode/execute register write |
| idex_mem_read_o | output | 1 | Decode/execute memory read |
| idex_reg_dst_o | output | 1 | Decode/execute destination select |
| exmem_rd_o | output | 4 | Execute/memory destination |
| exmem_reg_write_o | output | 1 | Execute/memory register write |
| memwb_rd_o | output | 4 | Memory/writeback destination |
| memwb_reg_write_o | output | 1 | Memory/writeback register write |
| fwd_a_o | output | 2 | Forwarding select, first operand |
| fwd_b_o | output | 2 | Forwarding select, second operand |
| pc_write_o | output | 1 | Program counter may advance |
| ifid_write_o | output | 1 | Fetch/decode register may load |
| idex_flush_o | output | 1 | Bubble goes into decode/execute |

## Verification
An instruction presented in cycle N shows in the fetch/decode fields in cycle N+1. It shows in decode/execute in N+2, in execute/memory in N+3 and in memory/writeback in N+4. The forwarding selects and stall controls are combinational on the stage contents, so they are due in the same cycle as the stages they compare. The bench drives inputs on the falling edge and advances a stage-level model on each rising edge. The expected values for a cycle are queued on the falling edge, and the monitor compares them 1 ns later, well before the next rising edge.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  parameter int unsigned REG_W   = 4;
  parameter int unsigned OP_W    = 3;
  parameter int unsigned NUM_SRC = 2;

  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_ADDI = 3'd1,
    OP_OR   = 3'd2,
    OP_ORI  = 3'd3,
    OP_LW   = 3'd4,
    OP_SW   = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_e;

  typedef struct packed {
    logic vld;
    op_e  op;
    reg_t rs;
    reg_t rt;
    reg_t rd;
  } ifid_t;

  typedef struct packed {
    logic reg_write;
    logic mem_read;
    logic reg_dst;
    logic rt_src;
    reg_t rs;
    reg_t rt;
    reg_t rd;
  } idex_t;

  typedef struct packed {
    logic reg_write;
    reg_t rd;
  } wb_t;

  typedef struct packed {
    logic reg_write;
    logic mem_read;
    logic reg_dst;
    logic rt_src;
    logic rs_src;
  } ctrl_t;

  function automatic logic op_is_rtype(op_e op);
    return (op == OP_ADD) || (op == OP_OR);
  endfunction

  function automatic logic op_is_legal(op_e op);
    return op inside {OP_ADD, OP_ADDI, OP_OR, OP_ORI, OP_LW, OP_SW};
  endfunction
endpackage

// File: rtl/hfc_decode.sv
module hfc_decode
  import hfc_pkg::*;
(
  input  logic  vld_i,
  input  op_e   op_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o           = '0;
    ctrl_o.rs_src    = vld_i;
    ctrl_o.rt_src    = vld_i && (op_is_rtype(op_i) || op_i == OP_SW);
    ctrl_o.reg_write = vld_i && (op_i != OP_SW);
    ctrl_o.mem_read  = vld_i && (op_i == OP_LW);
    ctrl_o.reg_dst   = vld_i && op_is_rtype(op_i);
  end
endmodule

// File: rtl/hfc_hazard.sv
module hfc_hazard
  import hfc_pkg::*;
(
  input  reg_t ifid_rs_i,
  input  reg_t ifid_rt_i,
  input  logic rs_src_i,
  input  logic rt_src_i,
  input  logic idex_mem_read_i,
  input  reg_t idex_rt_i,
  output logic stall_o
);
  logic hit_rs, hit_rt;

  assign hit_rs  = rs_src_i && (ifid_rs_i == idex_rt_i);
  assign hit_rt  = rt_src_i && (ifid_rt_i == idex_rt_i);
  assign stall_o = idex_mem_read_i && (idex_rt_i != '0) && (hit_rs || hit_rt);
endmodule

// File: rtl/hfc_fwd_unit.sv
module hfc_fwd_unit
  import hfc_pkg::*;
(
  input  reg_t src_i,
  input  logic used_i,
  input  wb_t  exmem_i,
  input  wb_t  memwb_i,
  output fwd_e sel_o
);
  logic near_hit, far_hit;

  assign near_hit = exmem_i.reg_write && (exmem_i.rd != '0) && (exmem_i.rd == src_i);
  assign far_hit  = memwb_i.reg_write && (memwb_i.rd != '0) && (memwb_i.rd == src_i);

  always_comb begin
    if (!used_i)       sel_o = FWD_RF;
    else if (near_hit) sel_o = FWD_EXMEM;
    else if (far_hit)  sel_o = FWD_MEMWB;
    else               sel_o = FWD_RF;
  end
endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
  import hfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [REG_W-1:0] rd_i,
  output logic [REG_W-1:0] ifid_rs_o,
  output logic [REG_W-1:0] ifid_rt_o,
  output logic [REG_W-1:0] ifid_rd_o,
  output logic [REG_W-1:0] idex_rs_o,
  output logic [REG_W-1:0] idex_rt_o,
  output logic [REG_W-1:0] idex_rd_o,
  output logic             idex_reg_write_o,
  output logic             idex_mem_read_o,
  output logic             idex_reg_dst_o,
  output logic [REG_W-1:0] exmem_rd_o,
  output logic             exmem_reg_write_o,
  output logic [REG_W-1:0] memwb_rd_o,
  output logic             memwb_reg_write_o,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             pc_write_o,
  output logic             ifid_write_o,
  output logic             idex_flush_o
);
  ifid_t ifid_q, fetch_d;
  idex_t idex_q, idex_d;
  wb_t   exmem_q, exmem_d, memwb_q;
  ctrl_t dec;
  logic  stall;
  op_e   op_in;

  assign op_in = op_e'(op_i);

  // illegal codes and idle cycles enter as all-zero bubbles
  always_comb begin
    fetch_d = '0;
    if (valid_i && op_is_legal(op_in)) begin
      fetch_d.vld = 1'b1;
      fetch_d.op  = op_in;
      fetch_d.rs  = rs_i;
      fetch_d.rt  = rt_i;
      fetch_d.rd  = op_is_rtype(op_in) ? rd_i : '0;
    end
  end

  hfc_decode u_dec (
    .vld_i  (ifid_q.vld),
    .op_i   (ifid_q.op),
    .ctrl_o (dec)
  );

  hfc_hazard u_haz (
    .ifid_rs_i       (ifid_q.rs),
    .ifid_rt_i       (ifid_q.rt),
    .rs_src_i        (dec.rs_src),
    .rt_src_i        (dec.rt_src),
    .idex_mem_read_i (idex_q.mem_read),
    .idex_rt_i       (idex_q.rt),
    .stall_o         (stall)
  );

  always_comb begin
    idex_d = '0;
    if (!stall && ifid_q.vld) begin
      idex_d.reg_write = dec.reg_write;
      idex_d.mem_read  = dec.mem_read;
      idex_d.reg_dst   = dec.reg_dst;
      idex_d.rt_src    = dec.rt_src;
      idex_d.rs        = ifid_q.rs;
      idex_d.rt        = ifid_q.rt;
      idex_d.rd        = ifid_q.rd;
    end
  end

  always_comb begin
    exmem_d.reg_write = idex_q.reg_write;
    exmem_d.rd        = '0;
    if (idex_q.reg_write) exmem_d.rd = idex_q.reg_dst ? idex_q.rd : idex_q.rt;
  end

  reg_t src_sel [NUM_SRC];
  logic src_use [NUM_SRC];
  fwd_e fwd_sel [NUM_SRC];

  assign src_sel[0] = idex_q.rs;
  assign src_use[0] = 1'b1;
  assign src_sel[1] = idex_q.rt;
  assign src_use[1] = idex_q.rt_src;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
    hfc_fwd_unit u_fwd (
      .src_i   (src_sel[g]),
      .used_i  (src_use[g]),
      .exmem_i (exmem_q),
      .memwb_i (memwb_q),
      .sel_o   (fwd_sel[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      if (!stall) ifid_q <= fetch_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= exmem_q;
    end
  end

  assign ifid_rs_o         = ifid_q.rs;
  assign ifid_rt_o         = ifid_q.rt;
  assign ifid_rd_o         = ifid_q.rd;
  assign idex_rs_o         = idex_q.rs;
  assign idex_rt_o         = idex_q.rt;
  assign idex_rd_o         = idex_q.rd;
  assign idex_reg_write_o  = idex_q.reg_write;
  assign idex_mem_read_o   = idex_q.mem_read;
  assign idex_reg_dst_o    = idex_q.reg_dst;
  assign exmem_rd_o        = exmem_q.rd;
  assign exmem_reg_write_o = exmem_q.reg_write;
  assign memwb_rd_o        = memwb_q.rd;
  assign memwb_reg_write_o = memwb_q.reg_write;
  assign fwd_a_o           = fwd_sel[0];
  assign fwd_b_o           = fwd_sel[1];
  assign pc_write_o        = !stall;
  assign ifid_write_o      = !stall;
  assign idex_flush_o      = stall;
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker
  import hfc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] ifid_rs_o,
  input logic [REG_W-1:0] ifid_rt_o,
  input logic [REG_W-1:0] ifid_rd_o,
  input logic [REG_W-1:0] idex_rs_o,
  input logic [REG_W-1:0] idex_rt_o,
  input logic [REG_W-1:0] idex_rd_o,
  input logic             idex_reg_write_o,
  input logic             idex_mem_read_o,
  input logic             idex_reg_dst_o,
  input logic [REG_W-1:0] exmem_rd_o,
  input logic             exmem_reg_write_o,
  input logic [REG_W-1:0] memwb_rd_o,
  input logic             memwb_reg_write_o,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             pc_write_o,
  input logic             ifid_write_o,
  input logic             idex_flush_o
);
  AST_RD_ITYPE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_reg_dst_o |-> idex_rd_o == '0); // R4

  AST_EXMEM_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> exmem_reg_write_o == $past(idex_reg_write_o)); // R5

  AST_MEMWB_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (memwb_rd_o == $past(exmem_rd_o)) && (memwb_reg_write_o == $past(exmem_reg_write_o))); // R5

  AST_FWD_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11)); // R6

  AST_FWD_EXMEM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b10) |-> exmem_reg_write_o && (exmem_rd_o == idex_rs_o)); // R6

  AST_FWD_EXMEM_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exmem_reg_write_o && exmem_rd_o != '0 && exmem_rd_o == idex_rs_o) |-> fwd_a_o == 2'b10); // R7

  AST_NO_FWD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exmem_rd_o == '0) |-> (fwd_a_o != 2'b10) && (fwd_b_o != 2'b10)); // R8

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_write_o |-> idex_mem_read_o && (idex_rt_o != '0)); // R9

  AST_FLUSH_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_flush_o |=> !idex_reg_write_o && !idex_mem_read_o && idex_rs_o == '0 && idex_rt_o == '0); // R10

  AST_IFID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ifid_write_o |=> $stable(ifid_rs_o) && $stable(ifid_rt_o) && $stable(ifid_rd_o)); // R10
endmodule

bind hazard_fwd_ctrl hfc_checker u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .ifid_rs_o         (ifid_rs_o),
  .ifid_rt_o         (ifid_rt_o),
  .ifid_rd_o         (ifid_rd_o),
  .idex_rs_o         (idex_rs_o),
  .idex_rt_o         (idex_rt_o),
  .idex_rd_o         (idex_rd_o),
  .idex_reg_write_o  (idex_reg_write_o),
  .idex_mem_read_o   (idex_mem_read_o),
  .idex_reg_dst_o    (idex_reg_dst_o),
  .exmem_rd_o        (exmem_rd_o),
  .exmem_reg_write_o (exmem_reg_write_o),
  .memwb_rd_o        (memwb_rd_o),
  .memwb_reg_write_o (memwb_reg_write_o),
  .fwd_a_o           (fwd_a_o),
  .fwd_b_o           (fwd_b_o),
  .pc_write_o        (pc_write_o),
  .ifid_write_o      (ifid_write_o),
  .idex_flush_o      (idex_flush_o)
);

// File: tb/hazard_fwd_ctrl_tb_top.sv
`timescale 1ns/1ps
module hazard_fwd_ctrl_tb_top;
  typedef struct packed {
    logic       vld;
    logic [2:0] op;
    logic [3:0] rs;
    logic [3:0] rt;
    logic [3:0] rd;
  } ins_t;

  typedef struct {
    int    ifid_rs, ifid_rt, ifid_rd;
    int    idex_rs, idex_rt, idex_rd, idex_rw, idex_mr, idex_dst;
    int    exmem_rd, exmem_rw, memwb_rd, memwb_rw;
    int    fa, fb;
    int    stall;
    int    ifid_vld;
    int    prev_stall;
    string tag_a, tag_b;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       valid_i;
  logic [2:0] op_i;
  logic [3:0] rs_i, rt_i, rd_i;
  logic [3:0] ifid_rs_o, ifid_rt_o, ifid_rd_o, idex_rs_o, idex_rt_o, idex_rd_o;
  logic       idex_reg_write_o, idex_mem_read_o, idex_reg_dst_o;
  logic [3:0] exmem_rd_o, memwb_rd_o;
  logic       exmem_reg_write_o, memwb_reg_write_o;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic       pc_write_o, ifid_write_o, idex_flush_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  hazard_fwd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .rs_i(rs_i), .rt_i(rt_i), .rd_i(rd_i),
    .ifid_rs_o(ifid_rs_o), .ifid_rt_o(ifid_rt_o), .ifid_rd_o(ifid_rd_o),
    .idex_rs_o(idex_rs_o), .idex_rt_o(idex_rt_o), .idex_rd_o(idex_rd_o),
    .idex_reg_write_o(idex_reg_write_o), .idex_mem_read_o(idex_mem_read_o),
    .idex_reg_dst_o(idex_reg_dst_o),
    .exmem_rd_o(exmem_rd_o), .exmem_reg_write_o(exmem_reg_write_o),
    .memwb_rd_o(memwb_rd_o), .memwb_reg_write_o(memwb_reg_write_o),
    .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o),
    .pc_write_o(pc_write_o), .ifid_write_o(ifid_write_o), .idex_flush_o(idex_flush_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // stage-level reference model
  ins_t m_ifid, m_idex, m_exmem, m_memwb;
  logic m_prev_stall;
  exp_t exp_q[$];
  ins_t prog[$];

  function automatic logic is_rt(logic [2:0] op);
    return op == 3'd0 || op == 3'd2;
  endfunction
  function automatic logic writes(ins_t r);
    return r.vld && r.op != 3'd5;
  endfunction
  function automatic int dst_of(ins_t r);
    if (!writes(r)) return 0;
    return is_rt(r.op) ? int'(r.rd) : int'(r.rt);
  endfunction
  function automatic int raw_dst(ins_t r);
    return is_rt(r.op) ? int'(r.rd) : int'(r.rt);
  endfunction
  function automatic logic reads_rt(ins_t r);
    return r.vld && (is_rt(r.op) || r.op == 3'd5);
  endfunction

  function automatic int fwd_exp(int src, logic used, ins_t ex, ins_t wb, output string tag);
    logic e, w;
    e = dst_of(ex) != 0 && dst_of(ex) == src;
    w = dst_of(wb) != 0 && dst_of(wb) == src;
    tag = "R6";
    if (!used) return 0;
    if (e && w) tag = "R7";
    else if ((!e && ex.vld && raw_dst(ex) == src) || (!w && wb.vld && raw_dst(wb) == src)) tag = "R8";
    if (e) return 2;
    if (w) return 1;
    return 0;
  endfunction

  function automatic exp_t model_out();
    exp_t x;
    string ta, tb;
    x.ifid_vld   = int'(m_ifid.vld);
    x.ifid_rs    = m_ifid.vld ? int'(m_ifid.rs) : 0;
    x.ifid_rt    = m_ifid.vld ? int'(m_ifid.rt) : 0;
    x.ifid_rd    = (m_ifid.vld && is_rt(m_ifid.op)) ? int'(m_ifid.rd) : 0;
    x.idex_rs    = m_idex.vld ? int'(m_idex.rs) : 0;
    x.idex_rt    = m_idex.vld ? int'(m_idex.rt) : 0;
    x.idex_rd    = (m_idex.vld && is_rt(m_idex.op)) ? int'(m_idex.rd) : 0;
    x.idex_rw    = int'(writes(m_idex));
    x.idex_mr    = int'(m_idex.vld && m_idex.op == 3'd4);
    x.idex_dst   = int'(m_idex.vld && is_rt(m_idex.op));
    x.exmem_rd   = dst_of(m_exmem);
    x.exmem_rw   = int'(writes(m_exmem));
    x.memwb_rd   = dst_of(m_memwb);
    x.memwb_rw   = int'(writes(m_memwb));
    x.fa         = fwd_exp(x.idex_rs, m_idex.vld, m_exmem, m_memwb, ta);
    x.fb         = fwd_exp(x.idex_rt, reads_rt(m_idex), m_exmem, m_memwb, tb);
    x.tag_a      = ta;
    x.tag_b      = tb;
    x.stall      = int'(m_idex.vld && m_idex.op == 3'd4 && m_idex.rt != 0 && m_ifid.vld &&
                        (m_ifid.rs == m_idex.rt || (reads_rt(m_ifid) && m_ifid.rt == m_idex.rt)));
    x.prev_stall = int'(m_prev_stall);
    return x;
  endfunction

  function automatic ins_t mk(logic v, int op, int rs, int rt, int rd);
    ins_t r;
    r.vld = v; r.op = 3'(op); r.rs = 4'(rs); r.rt = 4'(rt); r.rd = 4'(rd);
    return r;
  endfunction

  // monitor: pops queued expectations after the falling edge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      string ti, tx;
      e  = exp_q.pop_front();
      ti = e.prev_stall != 0 ? "R10" : (e.ifid_vld != 0 ? "R2" : "R3");
      tx = e.prev_stall != 0 ? "R10" : "R4";
      chk(ti, "ifid_rs", int'(ifid_rs_o), e.ifid_rs);
      chk(ti, "ifid_rt", int'(ifid_rt_o), e.ifid_rt);
      chk(ti, "ifid_rd", int'(ifid_rd_o), e.ifid_rd);
      chk(tx, "idex_rs", int'(idex_rs_o), e.idex_rs);
      chk(tx, "idex_rt", int'(idex_rt_o), e.idex_rt);
      chk(tx, "idex_rd", int'(idex_rd_o), e.idex_rd);
      chk(tx, "idex_reg_write", int'(idex_reg_write_o), e.idex_rw);
      chk(tx, "idex_mem_read", int'(idex_mem_read_o), e.idex_mr);
      chk(tx, "idex_reg_dst", int'(idex_reg_dst_o), e.idex_dst);
      chk("R5", "exmem_rd", int'(exmem_rd_o), e.exmem_rd);
      chk("R5", "exmem_reg_write", int'(exmem_reg_write_o), e.exmem_rw);
      chk("R5", "memwb_rd", int'(memwb_rd_o), e.memwb_rd);
      chk("R5", "memwb_reg_write", int'(memwb_reg_write_o), e.memwb_rw);
      chk(e.tag_a, "fwd_a", int'(fwd_a_o), e.fa);
      chk(e.tag_b, "fwd_b", int'(fwd_b_o), e.fb);
      chk("R9", "pc_write", int'(pc_write_o), 1 - e.stall);
      chk("R9", "ifid_write", int'(ifid_write_o), 1 - e.stall);
      chk("R9", "idex_flush", int'(idex_flush_o), e.stall);
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    int   ptr;
    int   drain;
    ins_t p;
    exp_t e;
    // two dependent ALU ops, forward from execute/memory
    prog.push_back(mk(1, 0, 2, 3, 1));
    prog.push_back(mk(1, 1, 1, 4, 9));
    prog.push_back(mk(0, 0, 0, 0, 0));
    // memory/writeback forward on both operands
    prog.push_back(mk(1, 0, 1, 2, 5));
    prog.push_back(mk(1, 2, 3, 4, 6));
    prog.push_back(mk(1, 2, 5, 5, 7));
    // both later stages write $2: priority
    prog.push_back(mk(1, 1, 1, 2, 0));
    prog.push_back(mk(1, 3, 2, 2, 0));
    prog.push_back(mk(1, 0, 2, 2, 3));
    // load-use on rs
    prog.push_back(mk(1, 4, 1, 3, 0));
    prog.push_back(mk(1, 0, 3, 2, 4));
    // load then store of loaded register (rt source)
    prog.push_back(mk(1, 4, 2, 5, 0));
    prog.push_back(mk(1, 5, 6, 5, 0));
    // load then immediate add writing same rt: no stall
    prog.push_back(mk(1, 4, 2, 6, 0));
    prog.push_back(mk(1, 1, 7, 6, 0));
    // load, gap, use: forward from memory/writeback
    prog.push_back(mk(1, 4, 3, 1, 0));
    prog.push_back(mk(0, 2, 5, 5, 5));
    prog.push_back(mk(1, 0, 1, 1, 2));
    // store writes nothing
    prog.push_back(mk(1, 5, 1, 4, 0));
    prog.push_back(mk(1, 0, 4, 4, 5));
    // destination $0 never forwards
    prog.push_back(mk(1, 1, 1, 0, 0));
    prog.push_back(mk(1, 0, 0, 0, 2));
    // reserved codes and idle with garbage fields
    prog.push_back(mk(1, 6, 3, 3, 3));
    prog.push_back(mk(1, 7, 4, 4, 4));
    prog.push_back(mk(0, 1, 8, 8, 8));
    prog.push_back(mk(1, 3, 8, 7, 6));
    prog.push_back(mk(1, 2, 7, 8, 1));

    rst_ni = 1'b0; valid_i = 1'b1; op_i = 3'd0; rs_i = 4'd2; rt_i = 4'd3; rd_i = 4'd4;
    m_ifid = '0; m_idex = '0; m_exmem = '0; m_memwb = '0; m_prev_stall = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset ifid_rs", int'(ifid_rs_o), 0);
    chk("R1", "reset idex_reg_write", int'(idex_reg_write_o), 0);
    chk("R1", "reset exmem_rd", int'(exmem_rd_o), 0);
    chk("R1", "reset memwb_reg_write", int'(memwb_reg_write_o), 0);
    chk("R1", "reset fwd_a", int'(fwd_a_o), 0);
    chk("R1", "reset pc_write", int'(pc_write_o), 1);
    chk("R1", "reset ifid_write", int'(ifid_write_o), 1);
    chk("R1", "reset idex_flush", int'(idex_flush_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    ptr = 0;
    drain = 0;
    while (ptr < prog.size() || drain < 6) begin
      e = model_out();
      exp_q.push_back(e);
      if (e.stall != 0) p = mk(1, 0, 7, 7, 7);   // fetched during stall, must be dropped
      else if (ptr < prog.size()) begin p = prog[ptr]; ptr++; end
      else begin p = '0; drain++; end
      valid_i = p.vld; op_i = p.op; rs_i = p.rs; rt_i = p.rt; rd_i = p.rd;
      @(posedge clk);
      m_memwb = m_exmem;
      m_exmem = m_idex;
      m_idex  = (e.stall != 0) ? ins_t'('0) : m_ifid;
      if (e.stall == 0) m_ifid = (p.vld && p.op <= 3'd5) ? p : ins_t'('0);
      m_prev_stall = (e.stall != 0);
      @(negedge clk);
    end
    #2;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule